// File: doc/BRIEF.md
# Amplitude Modulator with Selectable Depth

This block turns a signed carrier sample stream into an amplitude-modulated stream for a 12-bit DAC. The carrier typically comes from a numerically controlled oscillator. A second signed stream carries the modulating tone, typically a 1 kHz sine read from a sample table. Each output sample is formed as the carrier plus the carrier multiplied by the depth-scaled modulating sample. The envelope therefore follows 1 + depth·m(t).

The depth is a small integer code from 1 to 10, meaning 10 % to 100 % in 10 % steps. The code is written into a depth register, which turns it into an eight-bit binary fraction. The carrier is halved before mixing, so a full-scale sample at full depth reaches the code range without clipping. A saturation stage still guards the output. The signed result is moved into offset-binary by inverting its sign bit, which adds half of full scale. The datapath has three pipeline stages, and a valid flag travels through the pipeline with each sample.

Top module: `am_mod_top`

## Requirements
- R1: While reset is asserted, and right after it is released, `outValid` is 0 and `dacCode` is 2048. Until the first depth write, the depth code is 5.
- R2: A sample accepted with `inValid` = 1 at a rising clock edge gives `outValid` = 1 and its result on `dacCode` right after the third rising edge, counting the edge that accepted the sample. `outValid` is 1 at no other time.
- R3: Let h = carrier >>> 1, s = (modSample·q + 128) >>> 8 and t = (s·h + 1024) >>> 11, where >>> is an arithmetic (floor) shift and q is the depth fraction. Then the output is `dacCode` = clamp(h + t, −2048, 2047) + 2048.
- R4: A depth code k from 1 to 10 gives q = floor((k·256 + 5) / 10). So k = 1 gives 26, k = 5 gives 128 and k = 10 gives 256.
- R5: Depth code 0 acts as code 1. Depth codes 11 to 15 act as code 10.
- R6: A depth write with `depthWe` = 1 at an edge applies to samples accepted at later edges. A sample accepted at the same edge as the write, and any sample already in the pipeline, still uses the old depth.
- R7: When `outValid` is 0, `dacCode` keeps the last value it had.
- R8: A `modSample` of 0 gives `dacCode` = (carrier >>> 1) + 2048 at any depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| depthWe | input | 1 | Loads `depthCode` into the depth register |
| depthCode | input | 4 | Modulation depth in tenths, valid range 1 to 10 |
| inValid | input | 1 | The carrier and modulating samples are valid this cycle |
| carrier | input | 12 | Signed carrier sample |
| modSample | input | 12 | Signed modulating sample, where 2048 stands for 1.0 |
| outValid | output | 1 | `dacCode` holds a new result |
| dacCode | output | 12 | Offset-binary DAC code |

## Verification
Each accepted sample's result is due right after the third rising edge, counting the edge that took the sample in. A depth write applies only to samples taken at later edges. The bench drives its inputs on falling edges and keeps a cycle counter. Each expected value is stored together with the counter value at the moment its sample was driven. At every falling edge the bench checks that `outValid` is high exactly when the oldest stored entry is three counts old, and at that point compares `dacCode` against the stored value. On idle falling edges it checks that the output code still holds the previous result.

// File: rtl/am_mod_pkg.sv
package am_mod_pkg;

  localparam int DEPTH_FRAC  = 8;
  localparam int DEPTH_W     = DEPTH_FRAC + 1;
  localparam int DEPTH_STEPS = 10;
  localparam int PIPE_LAT    = 3;

  typedef struct packed {
    logic               ld1;
    logic               ld2;
    logic               ld3;
    logic [DEPTH_W-1:0] depthQ;
  } amCtl_t;

  // Clamp the depth code into 1..DEPTH_STEPS and turn it into a fraction
  // with DEPTH_FRAC fractional bits, rounded to nearest.
  function automatic logic [DEPTH_W-1:0] depthToQ(input int unsigned code);
    int unsigned c;
    c = (code < 1) ? 1 : ((code > DEPTH_STEPS) ? DEPTH_STEPS : code);
    return DEPTH_W'((c * (32'd1 << DEPTH_FRAC) + DEPTH_STEPS / 2) / DEPTH_STEPS);
  endfunction

endpackage

// File: rtl/am_mod_ctrl.sv
module am_mod_ctrl
  import am_mod_pkg::*;
#(
  parameter int CODE_W     = 4,
  parameter int RESET_CODE = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              depthWe,
  input  logic [CODE_W-1:0] depthCode,
  input  logic              inValid,
  output amCtl_t            ctl,
  output logic              outValid
);

  localparam logic [DEPTH_W-1:0] RESET_Q = depthToQ(RESET_CODE);

  logic [DEPTH_W-1:0]  depthQReg;
  logic [PIPE_LAT-1:0] vPipe;

  // Depth register: the stage-1 multiply reads the old value on the write edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        depthQReg <= RESET_Q;
    else if (depthWe) depthQReg <= depthToQ(int'(depthCode));
  end

  // Valid shift register that travels alongside the data stages.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[PIPE_LAT-2:0], inValid};
  end

  always_comb begin
    ctl.ld1    = inValid;
    ctl.ld2    = vPipe[0];
    ctl.ld3    = vPipe[1];
    ctl.depthQ = depthQReg;
  end

  assign outValid = vPipe[PIPE_LAT-1];

endmodule

// File: rtl/am_mod_dp.sv
module am_mod_dp
  import am_mod_pkg::*;
#(
  parameter int CW = 12,
  parameter int MW = 12,
  parameter int OW = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  amCtl_t               ctl,
  input  logic signed [CW-1:0] carrier,
  input  logic signed [MW-1:0] modSample,
  output logic        [OW-1:0] dacCode
);

  localparam int PA_W = MW + DEPTH_W + 1;
  localparam int PB_W = MW + CW;
  localparam int SW   = ((OW > CW) ? OW : CW) + 1;
  localparam logic signed [SW-1:0] SAT_HI = SW'((1 << (OW - 1)) - 1);
  localparam logic signed [SW-1:0] SAT_LO = SW'(-(1 << (OW - 1)));
  localparam logic        [OW-1:0] MID    = OW'(1 << (OW - 1));

  // Stage 1: halve the carrier, scale the modulating sample by the depth
  logic signed [PA_W-1:0] modExt, depthExt, prodA;
  logic signed [MW-1:0]   scaledS1;
  logic signed [CW-1:0]   halfS1;

  assign modExt   = PA_W'(modSample);
  assign depthExt = PA_W'($signed({1'b0, ctl.depthQ}));
  assign prodA    = modExt * depthExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scaledS1 <= '0;
      halfS1   <= '0;
    end else if (ctl.ld1) begin
      scaledS1 <= MW'((prodA + PA_W'(1 << (DEPTH_FRAC - 1))) >>> DEPTH_FRAC);
      halfS1   <= carrier >>> 1;
    end
  end

  // Stage 2: multiply the scaled tone by the halved carrier
  logic signed [PB_W-1:0] scaledExt, halfExt, prodB;
  logic signed [CW-1:0]   termS2, halfS2;

  assign scaledExt = PB_W'(scaledS1);
  assign halfExt   = PB_W'(halfS1);
  assign prodB     = scaledExt * halfExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      termS2 <= '0;
      halfS2 <= '0;
    end else if (ctl.ld2) begin
      termS2 <= CW'((prodB + PB_W'(1 << (MW - 2))) >>> (MW - 1));
      halfS2 <= halfS1;
    end
  end

  // Stage 3: add the carrier back, align to the output width, saturate, offset
  logic signed [CW:0]    sum;
  logic signed [SW-1:0]  aligned;
  logic signed [OW-1:0]  satVal;

  assign sum = (CW + 1)'(halfS2) + (CW + 1)'(termS2);

  generate
    if (OW > CW) begin : g_widen
      assign aligned = SW'(sum) <<< (OW - CW);
    end else if (OW < CW) begin : g_narrow
      assign aligned = SW'(sum >>> (CW - OW));
    end else begin : g_same
      assign aligned = SW'(sum);
    end
  endgenerate

  always_comb begin
    if (aligned > SAT_HI)      satVal = OW'(SAT_HI);
    else if (aligned < SAT_LO) satVal = OW'(SAT_LO);
    else                       satVal = OW'(aligned);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        dacCode <= MID;
    else if (ctl.ld3) dacCode <= {~satVal[OW-1], satVal[OW-2:0]};
  end

endmodule

// File: rtl/am_mod_top.sv
module am_mod_top
  import am_mod_pkg::*;
#(
  parameter int CW     = 12,
  parameter int MW     = 12,
  parameter int OW     = 12,
  parameter int CODE_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 depthWe,
  input  logic [CODE_W-1:0]    depthCode,
  input  logic                 inValid,
  input  logic signed [CW-1:0] carrier,
  input  logic signed [MW-1:0] modSample,
  output logic                 outValid,
  output logic [OW-1:0]        dacCode
);

  amCtl_t ctlBus;

  am_mod_ctrl #(.CODE_W(CODE_W), .RESET_CODE(5)) u_ctrl (
    .clk(clk), .rstN(rstN), .depthWe(depthWe), .depthCode(depthCode),
    .inValid(inValid), .ctl(ctlBus), .outValid(outValid)
  );

  am_mod_dp #(.CW(CW), .MW(MW), .OW(OW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .carrier(carrier),
    .modSample(modSample), .dacCode(dacCode)
  );

endmodule

// File: rtl/am_mod_chk.sv
module am_mod_chk
  import am_mod_pkg::*;
#(
  parameter int OW     = 12,
  parameter int CODE_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               depthWe,
  input logic [CODE_W-1:0]  depthCode,
  input logic               inValid,
  input logic               outValid,
  input logic [OW-1:0]      dacCode,
  input logic [DEPTH_W-1:0] depthQ
);

  logic [1:0] warmCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                warmCnt <= '0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end

  // R1: reset state at the ports
  always @(negedge clk) begin
    if (!rstN) begin
      a_r1_reset_state: assert (!outValid && dacCode == OW'(1 << (OW - 1)))
        else $error("reset state wrong");
    end
  end

  // R2: output valid exactly three edges after input valid
  a_r2_latency: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == 2'd3) |-> (outValid == $past(inValid, 3)));

  // R7: output code holds while no result is presented
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(dacCode));

  // R4: full-depth code gives unity fraction
  a_r4_full_depth: assert property (@(posedge clk) disable iff (!rstN)
    (depthWe && depthCode == CODE_W'(10)) |=> (depthQ == DEPTH_W'(256)));

  // R5: code 0 clamps to the 10 % fraction
  a_r5_zero_clamp: assert property (@(posedge clk) disable iff (!rstN)
    (depthWe && depthCode == '0) |=> (depthQ == DEPTH_W'(26)));

  // R5: stored fraction never leaves the 10 %..100 % span
  a_r5_depth_range: assert property (@(posedge clk) disable iff (!rstN)
    (depthQ >= DEPTH_W'(26)) && (depthQ <= DEPTH_W'(256)));

endmodule

bind am_mod_top am_mod_chk #(.OW(OW), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .depthWe(depthWe), .depthCode(depthCode),
  .inValid(inValid), .outValid(outValid), .dacCode(dacCode),
  .depthQ(ctlBus.depthQ)
);

// File: tb/am_mod_top_tb.sv
module am_mod_top_tb;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              depthWe = 1'b0;
  logic [3:0]        depthCode = '0;
  logic              inValid = 1'b0;
  logic signed [11:0] carrier = '0;
  logic signed [11:0] modSample = '0;
  logic              outValid;
  logic [11:0]       dacCode;

  int cnt = 0;
  int nChecks = 0;
  int nFails = 0;
  int modelCode = 5;
  int lastOut = 2048;
  bit finished = 1'b0;
  int    expQ[$];
  int    cycQ[$];
  string reqQ[$];

  always #4 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 1;

  am_mod_top u_dut (
    .clk(clk), .rstN(rstN), .depthWe(depthWe), .depthCode(depthCode),
    .inValid(inValid), .carrier(carrier), .modSample(modSample),
    .outValid(outValid), .dacCode(dacCode)
  );

  function automatic int depthQ(input int code);
    int c;
    c = (code < 1) ? 1 : ((code > 10) ? 10 : code);
    return (c * 256 + 5) / 10;
  endfunction

  function automatic int expOut(input int code, input int car, input int m);
    int h, s, t, y;
    h = car >>> 1;
    s = (m * depthQ(code) + 128) >>> 8;
    t = (s * h + 1024) >>> 11;
    y = h + t;
    if (y > 2047) y = 2047;
    if (y < -2048) y = -2048;
    return y + 2048;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cnt);
    end
  endtask

  task automatic observe();
    if (outValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R2 spurious outValid", 1, 0);
      end else begin
        int e, c;
        string r;
        e = expQ.pop_front();
        c = cycQ.pop_front();
        r = reqQ.pop_front();
        chk(cnt - c == 3, "R2 latency", cnt - c, 3);
        chk(int'(dacCode) == e, r, int'(dacCode), e);
      end
      lastOut = int'(dacCode);
    end else begin
      if (cycQ.size() != 0 && cnt - cycQ[0] >= 3)
        chk(1'b0, "R2 missing outValid", 0, 1);
      chk(int'(dacCode) == lastOut, "R7 hold", int'(dacCode), lastOut);
    end
  endtask

  task automatic step(input bit v, input int car, input int m,
                      input bit we, input int code, input string req);
    @(negedge clk);
    observe();
    inValid   = v;
    carrier   = car[11:0];
    modSample = m[11:0];
    depthWe   = we;
    depthCode = code[3:0];
    if (v) begin
      expQ.push_back(expOut(modelCode, car, m));
      cycQ.push_back(cnt);
      reqQ.push_back(req);
    end
    if (we) modelCode = code;
  endtask

  task automatic drain();
    for (int i = 0; i < 5; i++) step(1'b0, 0, 0, 1'b0, 0, "");
  endtask

  initial begin
    int mods[6];
    int cars[3];
    int tones[3];
    mods  = '{-2048, -1000, 0, 1, 1500, 2047};
    cars  = '{2047, -2048, 1200};
    tones = '{2047, -2048, 777};

    repeat (3) @(negedge clk);
    chk(!outValid, "R1 outValid in reset", int'(outValid), 0);
    chk(dacCode == 12'd2048, "R1 dacCode in reset", int'(dacCode), 2048);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!outValid, "R1 outValid after reset", int'(outValid), 0);
    chk(dacCode == 12'd2048, "R1 dacCode after reset", int'(dacCode), 2048);

    // R1 default depth and R3 main formula: back-to-back carrier/tone sweep
    for (int c = -2048; c < 2048; c += 273)
      foreach (mods[j]) step(1'b1, c, mods[j], 1'b0, 0, "R1/R3 default-depth sweep");
    drain();

    // R8: zero tone leaves the halved carrier only, at several depths
    for (int k = 1; k <= 10; k += 3) begin
      step(1'b0, 0, 0, 1'b1, k, "");
      for (int c = -2048; c < 2048; c += 511) step(1'b1, c, 0, 1'b0, 0, "R8 zero tone");
    end
    drain();

    // R4 and R5: every depth code including clamped ones
    for (int k = 0; k < 16; k++) begin
      step(1'b0, 0, 0, 1'b1, k, "");
      foreach (cars[a])
        foreach (tones[b])
          step(1'b1, cars[a], tones[b], 1'b0, 0, (k == 0 || k > 10) ? "R5 clamp" : "R4 depth code");
    end
    drain();

    // R6: depth written on the same edge as a sample, every cycle
    for (int i = 0; i < 24; i++)
      step(1'b1, 1900 - i * 150, 2047 - i * 170, 1'b1, (i * 7) % 16, "R6 write timing");
    drain();

    // R7: irregular valid pattern with gaps
    for (int i = 0; i < 40; i++)
      step((i % 3 == 0) || (i % 7 == 1), -1500 + i * 80, 1800 - i * 90, 1'b0, 0, "R7 gapped stream");
    drain();

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule